// File: doc/BRIEF.md
# Multi-Source Reset Sequencing Controller

This block gathers every reason the system may need to reset and turns each into one timed reset sequence. It watches a power-on reset input, the levels of two shared open-drain reset lines (hard and soft), an expiry flag from a software watchdog, an expiry flag from a bus monitor and a soft-reset request from the JTAG test logic. It sorts each request into one of three classes: power-on, hard or soft. It then holds the matching reset outputs for a fixed number of cycles.

The block drives the two shared lines only by enabling a pull-down, and it reads their levels back. A line pulled low by another device starts a sequence only if the pull begins while the block is idle. After its timed phase the block releases its pull-downs and waits until both lines read high. Only then does it report the system out of reset.

Three other outputs serve the rest of the chip. The core reset covers any sequence, the wider logic reset covers hard and power-on sequences, and a one-cycle strobe tells configuration logic when to capture its strap values after power-on. A six-bit sticky register records which causes were accepted, and software clears it by writing ones.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, and for SEQ_LEN cycles after it rises, `hrst_oe_o`, `srst_oe_o`, `core_rst_o` and `logic_rst_o` are all 1. The cause register reads 6'h01, with only bit 0 (power-on) set.
- R2: `cfg_sample_o` is 1 for exactly one cycle per power-on sequence, on its last pull-down cycle. It is never 1 in a hard or soft sequence.
- R3: A hard sequence holds both `hrst_oe_o` and `srst_oe_o` at 1 for exactly SEQ_LEN cycles, with `core_rst_o` and `logic_rst_o` at 1. It is started by `wdog_expired_i`, by `busmon_expired_i`, or by a fall of `hrst_pin_i` that the block did not cause.
- R4: A soft sequence holds `srst_oe_o` at 1 for exactly SEQ_LEN cycles with `core_rst_o` at 1, while `hrst_oe_o` and `logic_rst_o` stay 0. It is started by `jtag_soft_req_i` or by an external fall of `srst_pin_i`.
- R5: Whenever `hrst_oe_o` is 1, `srst_oe_o` is also 1.
- R6: A fall of either pin level is acted on only if it happens while the block is idle. A fall during any sequence neither changes the sequence nor sets a cause bit.
- R7: After the timed phase, both pull-downs release. `core_rst_o` (and `logic_rst_o` for hard sequences) stays 1 until both pin levels read high, and falls on the cycle after that.
- R8: When hard and soft requests arrive together in idle, a hard sequence runs and only the hard causes present are recorded.
- R9: A watchdog or bus monitor expiry during a soft sequence turns it into a hard sequence. The hard sequence runs a full SEQ_LEN cycles from that point.
- R10: A soft request during a hard or power-on sequence is ignored. The outputs keep their timing and no cause bit is set.
- R11: Cause bits, once set, stay set until cleared. Bit assignments: 0 power-on, 1 external hard, 2 external soft, 3 watchdog, 4 bus monitor, 5 JTAG. A bit is set in the cycle after its request is accepted.
- R12: With `clr_we_i` at 1, every bit that is 1 in `clr_mask_i` clears at the next edge, unless the same bit is being set in that cycle; setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hrst_pin_i | input | 1 | Level sensed on the hard reset line (low = asserted) |
| srst_pin_i | input | 1 | Level sensed on the soft reset line (low = asserted) |
| wdog_expired_i | input | 1 | Enabled software watchdog reached zero |
| busmon_expired_i | input | 1 | Enabled bus monitor reached zero |
| jtag_soft_req_i | input | 1 | Soft reset request from test logic |
| clr_we_i | input | 1 | Cause register clear strobe |
| clr_mask_i | input | 6 | Write-one-to-clear mask for cause bits |
| hrst_oe_o | output | 1 | Enable pull-down on the hard reset line |
| srst_oe_o | output | 1 | Enable pull-down on the soft reset line |
| cfg_sample_o | output | 1 | One-cycle strobe to capture configuration after power-on |
| core_rst_o | output | 1 | Core reset |
| logic_rst_o | output | 1 | Reset of the other on-chip logic |
| cause_o | output | 6 | Sticky reset cause bits |

## Verification
A counter that is off by one shows at once as a pull-down window one cycle too long or too short. A sequence class stored wrongly shows within one cycle as `hrst_oe_o` or `logic_rst_o` at the wrong level. A fault in the edge detector or the idle gating shows as a sequence starting, or a cause bit rising, on the cycle after a pin level changes mid-sequence. A wrong release handshake keeps `core_rst_o` high, or drops it early, in the cycles around the release of an externally held line.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    KIND_SOFT = 2'd0,
    KIND_HARD = 2'd1,
    KIND_POR  = 2'd2
  } rst_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  localparam int NCAUSE = 6;
  localparam int C_POR  = 0;
  localparam int C_EXTH = 1;
  localparam int C_EXTS = 2;
  localparam int C_WDOG = 3;
  localparam int C_BMON = 4;
  localparam int C_JTAG = 5;

  localparam logic [NCAUSE-1:0] HARD_MASK = 6'b011010;
  localparam logic [NCAUSE-1:0] SOFT_MASK = 6'b100100;

  // True on the final cycle of the timed pull-down phase.
  function automatic logic cnt_is_last(input int unsigned cnt, input int unsigned len);
    return cnt == len - 1;
  endfunction

  // Causes kept when a request set wins: hard ones if any, else soft ones.
  function automatic logic [NCAUSE-1:0] winning_causes(input logic [NCAUSE-1:0] req);
    if ((req & HARD_MASK) != '0) return req & HARD_MASK;
    return req & SOFT_MASK;
  endfunction

endpackage

// File: rtl/rst_pin_sense.sv
module rst_pin_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic hrst_pin_i,
  input  logic srst_pin_i,
  output logic hrst_fall_o,
  output logic srst_fall_o,
  output logic pins_high_o
);
  logic hrst_prev_q, srst_prev_q;

  // Reset value low: the block itself holds both lines during power-on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hrst_prev_q <= 1'b0;
      srst_prev_q <= 1'b0;
    end else begin
      hrst_prev_q <= hrst_pin_i;
      srst_prev_q <= srst_pin_i;
    end
  end

  assign hrst_fall_o = hrst_prev_q & ~hrst_pin_i;
  assign srst_fall_o = srst_prev_q & ~srst_pin_i;
  assign pins_high_o = hrst_pin_i & srst_pin_i;
endmodule

// File: rtl/rst_req_classify.sv
module rst_req_classify
  import rst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_i,
  input  logic              soft_busy_i,
  input  logic              hrst_fall_i,
  input  logic              srst_fall_i,
  input  logic              wdog_i,
  input  logic              bmon_i,
  input  logic              jtag_i,
  output logic              start_hard_o,
  output logic              start_soft_o,
  output logic [NCAUSE-1:0] accept_o
);
  logic [NCAUSE-1:0] raw;
  logic              hard_any, soft_any;

  always_comb begin
    raw         = '0;
    raw[C_EXTH] = hrst_fall_i & idle_i;
    raw[C_EXTS] = srst_fall_i & idle_i;
    raw[C_WDOG] = wdog_i;
    raw[C_BMON] = bmon_i;
    raw[C_JTAG] = jtag_i;
  end

  assign hard_any     = (raw & HARD_MASK) != '0;
  assign soft_any     = (raw & SOFT_MASK) != '0;
  assign start_hard_o = hard_any & (idle_i | soft_busy_i);
  assign start_soft_o = soft_any & idle_i & ~hard_any;
  assign accept_o     = (start_hard_o | start_soft_o) ? winning_causes(raw) : '0;

  // R8: one class per decision
  a_r8_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_hard_o && start_soft_o));
  // R6: pin falls outside idle are never accepted
  a_r6_busy_pins_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |-> !accept_o[C_EXTH] && !accept_o[C_EXTS]);
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int SEQ_LEN = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_hard_i,
  input  logic start_soft_i,
  input  logic pins_high_i,
  output logic idle_o,
  output logic soft_busy_o,
  output logic hrst_oe_o,
  output logic srst_oe_o,
  output logic cfg_sample_o,
  output logic core_rst_o,
  output logic logic_rst_o
);
  localparam int CNT_W = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1;

  seq_state_e       state_q;
  rst_kind_e        kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last = cnt_is_last(int'(cnt_q), SEQ_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_DRIVE;
      kind_q  <= KIND_POR;
      cnt_q   <= '0;
    end else if (start_hard_i) begin
      state_q <= ST_DRIVE;
      kind_q  <= KIND_HARD;
      cnt_q   <= '0;
    end else if (start_soft_i) begin
      state_q <= ST_DRIVE;
      kind_q  <= KIND_SOFT;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_DRIVE: begin
          if (last) state_q <= ST_WAIT;
          else      cnt_q   <= cnt_q + 1'b1;
        end
        ST_WAIT:  if (pins_high_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o       = state_q == ST_IDLE;
  assign soft_busy_o  = !idle_o && kind_q == KIND_SOFT;
  assign srst_oe_o    = state_q == ST_DRIVE;
  assign hrst_oe_o    = srst_oe_o && kind_q != KIND_SOFT;
  assign cfg_sample_o = srst_oe_o && kind_q == KIND_POR && last;
  assign core_rst_o   = !idle_o;
  assign logic_rst_o  = !idle_o && kind_q != KIND_SOFT;

  // R5: the hard line is never pulled without the soft line
  a_r5_soft_covers_hard: assert property (@(posedge clk) disable iff (!rst_n)
    hrst_oe_o |-> srst_oe_o);
  // R3: the timed phase never runs past its length
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_DRIVE |-> int'(cnt_q) < SEQ_LEN);
  // R2: configuration strobe lasts one cycle and ends the pull-down
  a_r2_cfg_single: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sample_o |=> !cfg_sample_o && !srst_oe_o);
  // R7: stay in the release wait while a line is still low
  a_r7_wait_for_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !pins_high_i && !start_hard_i) |=> core_rst_o);
  // R10: a busy hard or power-on sequence never becomes soft
  a_r10_no_downgrade: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_o && kind_q != KIND_SOFT) |=> kind_q != KIND_SOFT);
endmodule

// File: rtl/rst_cause_status.sv
module rst_cause_status
  import rst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] accept_i,
  input  logic              clr_we_i,
  input  logic [NCAUSE-1:0] clr_mask_i,
  output logic [NCAUSE-1:0] cause_o
);
  logic [NCAUSE-1:0] cause_q, clr_eff;

  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= NCAUSE'(1) << C_POR;
    else        cause_q <= (cause_q & ~clr_eff) | accept_i;
  end

  assign cause_o = cause_q;

  // R1: the power-on bit is only set by the reset itself
  a_r1_por_bit_once: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_q[C_POR] |=> !cause_q[C_POR]);

  for (genvar i = 0; i < NCAUSE; i++) begin : g_bit
    // R11: sticky unless cleared
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_q[i] && !clr_eff[i]) |=> cause_q[i]);
    // R12: clear takes effect unless the bit is set at the same edge
    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_eff[i] && !accept_i[i]) |=> !cause_q[i]);
  end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int SEQ_LEN = 512
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hrst_pin_i,
  input  logic              srst_pin_i,
  input  logic              wdog_expired_i,
  input  logic              busmon_expired_i,
  input  logic              jtag_soft_req_i,
  input  logic              clr_we_i,
  input  logic [NCAUSE-1:0] clr_mask_i,
  output logic              hrst_oe_o,
  output logic              srst_oe_o,
  output logic              cfg_sample_o,
  output logic              core_rst_o,
  output logic              logic_rst_o,
  output logic [NCAUSE-1:0] cause_o
);
  logic              hrst_fall, srst_fall, pins_high;
  logic              idle, soft_busy, start_hard, start_soft;
  logic [NCAUSE-1:0] accept;

  rst_pin_sense u_sense (
    .clk(clk), .rst_n(por_n),
    .hrst_pin_i(hrst_pin_i), .srst_pin_i(srst_pin_i),
    .hrst_fall_o(hrst_fall), .srst_fall_o(srst_fall), .pins_high_o(pins_high)
  );

  rst_req_classify u_classify (
    .clk(clk), .rst_n(por_n),
    .idle_i(idle), .soft_busy_i(soft_busy),
    .hrst_fall_i(hrst_fall), .srst_fall_i(srst_fall),
    .wdog_i(wdog_expired_i), .bmon_i(busmon_expired_i), .jtag_i(jtag_soft_req_i),
    .start_hard_o(start_hard), .start_soft_o(start_soft), .accept_o(accept)
  );

  rst_seq_fsm #(.SEQ_LEN(SEQ_LEN)) u_fsm (
    .clk(clk), .rst_n(por_n),
    .start_hard_i(start_hard), .start_soft_i(start_soft), .pins_high_i(pins_high),
    .idle_o(idle), .soft_busy_o(soft_busy),
    .hrst_oe_o(hrst_oe_o), .srst_oe_o(srst_oe_o), .cfg_sample_o(cfg_sample_o),
    .core_rst_o(core_rst_o), .logic_rst_o(logic_rst_o)
  );

  rst_cause_status u_status (
    .clk(clk), .rst_n(por_n),
    .accept_i(accept), .clr_we_i(clr_we_i), .clr_mask_i(clr_mask_i),
    .cause_o(cause_o)
  );
endmodule

// File: tb/rst_seq_ctrl_bench.sv
`timescale 1ns/1ps
module rst_seq_ctrl_bench;
  localparam int LEN = 8;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_h = 1'b0, ext_s = 1'b0;
  logic       wdog = 1'b0, bmon = 1'b0, jtag = 1'b0;
  logic       clr_we = 1'b0;
  logic [5:0] clr_mask = '0;
  logic       hrst_oe, srst_oe, cfg_sample, core_rst, logic_rst;
  logic [5:0] cause;
  logic       hrst_pin, srst_pin;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  // Open-drain lines: low when the block or the bench pulls them.
  assign hrst_pin = ~(hrst_oe | ext_h);
  assign srst_pin = ~(srst_oe | ext_s);

  rst_seq_ctrl #(.SEQ_LEN(LEN)) u_rst_seq_ctrl (
    .clk(clk), .por_n(por_n), .hrst_pin_i(hrst_pin), .srst_pin_i(srst_pin),
    .wdog_expired_i(wdog), .busmon_expired_i(bmon), .jtag_soft_req_i(jtag),
    .clr_we_i(clr_we), .clr_mask_i(clr_mask),
    .hrst_oe_o(hrst_oe), .srst_oe_o(srst_oe), .cfg_sample_o(cfg_sample),
    .core_rst_o(core_rst), .logic_rst_o(logic_rst), .cause_o(cause)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge inside the pull-down phase; follows it to idle.
  task automatic run_seq(input bit hard, input bit por, input int exp_len, input string tag);
    int n = 0;
    while (srst_oe && n < 4 * LEN) begin
      chk(hrst_oe == (hard | por), {tag, " R5 hard line"}, hrst_oe, hard | por);
      chk(logic_rst == (hard | por), {tag, " logic reset"}, logic_rst, hard | por);
      chk(core_rst == 1'b1, {tag, " core reset"}, core_rst, 1);
      chk(cfg_sample == (por && n == exp_len - 1), {tag, " R2 cfg strobe"}, cfg_sample,
          por && n == exp_len - 1);
      n++;
      @(negedge clk);
    end
    chk(n == exp_len, {tag, " length"}, n, exp_len);
    chk(core_rst == 1'b1 && hrst_oe == 1'b0, {tag, " R7 release wait"}, core_rst, 1);
    @(negedge clk);
    chk(core_rst == 1'b0 && logic_rst == 1'b0, {tag, " R7 idle"}, core_rst, 0);
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr_mask = 6'h3f;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
    chk(cause == 6'h00, "R12 clear all", cause, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(hrst_oe && srst_oe && core_rst && logic_rst, "R1 outputs in reset",
        {hrst_oe, srst_oe, core_rst, logic_rst}, 4'hf);
    chk(cause == 6'h01, "R1 cause in reset", cause, 1);
    chk(cfg_sample == 1'b0, "R2 no strobe in reset", cfg_sample, 0);
    por_n = 1'b1;
    run_seq(1'b0, 1'b1, LEN, "R1 power-on");
    chk(cause == 6'h01, "R1 cause after power-on", cause, 1);
    clear_all();

    // R3 R4 R8 R11: every combination of the five non-power-on sources
    for (int m = 1; m < 32; m++) begin
      bit         hard;
      logic [5:0] exp;
      hard = m[0] | m[2] | m[3];
      exp = '0;
      if (hard) begin exp[1] = m[0]; exp[3] = m[2]; exp[4] = m[3]; end
      else      begin exp[2] = m[1]; exp[5] = m[4]; end
      ext_h = m[0]; ext_s = m[1]; wdog = m[2]; bmon = m[3]; jtag = m[4];
      @(negedge clk);
      ext_h = 0; ext_s = 0; wdog = 0; bmon = 0; jtag = 0;
      chk(cause == exp, $sformatf("R8 R11 causes combo %0d", m), cause, exp);
      run_seq(hard, 1'b0, LEN, hard ? "R3 hard combo" : "R4 soft combo");
      chk(cause == exp, "R11 causes sticky", cause, exp);
      clear_all();
    end

    // R9: watchdog during a soft sequence restarts as hard
    jtag = 1; @(negedge clk); jtag = 0;
    repeat (2) @(negedge clk);
    chk(hrst_oe == 1'b0, "R4 soft before upgrade", hrst_oe, 0);
    wdog = 1; @(negedge clk); wdog = 0;
    run_seq(1'b1, 1'b0, LEN, "R9 upgraded");
    chk(cause == 6'h28, "R9 causes", cause, 6'h28);
    clear_all();

    // R10: JTAG request during a hard sequence is ignored
    bmon = 1; @(negedge clk); bmon = 0;
    @(negedge clk);
    jtag = 1; @(negedge clk); jtag = 0;
    run_seq(1'b1, 1'b0, LEN - 2, "R10 hard unchanged");
    chk(cause == 6'h10, "R10 no jtag cause", cause, 6'h10);
    clear_all();

    // R6: external hard pull during a soft sequence is not recognised
    jtag = 1; @(negedge clk); jtag = 0;
    ext_h = 1; @(negedge clk); ext_h = 0;
    run_seq(1'b0, 1'b0, LEN - 1, "R6 soft unchanged");
    chk(cause == 6'h20, "R6 no ext hard cause", cause, 6'h20);
    clear_all();

    // R7: external line held past the timed phase
    wdog = 1; @(negedge clk); wdog = 0;
    ext_h = 1;
    while (srst_oe) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      chk(core_rst && logic_rst && !hrst_oe, "R7 held by external line",
          {core_rst, logic_rst, hrst_oe}, 3'b110);
      @(negedge clk);
    end
    ext_h = 0;
    @(negedge clk);
    chk(core_rst == 1'b0, "R7 idle after external release", core_rst, 0);
    chk(cause == 6'h08, "R6 R11 held line adds no cause", cause, 6'h08);
    clear_all();

    // R12: set wins over clear; partial clear
    wdog = 1; clr_we = 1; clr_mask = 6'h08;
    @(negedge clk);
    wdog = 0; clr_we = 0; clr_mask = '0;
    chk(cause == 6'h08, "R12 set beats clear", cause, 6'h08);
    run_seq(1'b1, 1'b0, LEN, "R12 seq a");
    jtag = 1; @(negedge clk); jtag = 0;
    run_seq(1'b0, 1'b0, LEN, "R12 seq b");
    chk(cause == 6'h28, "R11 accumulate", cause, 6'h28);
    clr_we = 1; clr_mask = 6'h08; @(negedge clk); clr_we = 0; clr_mask = '0;
    chk(cause == 6'h20, "R12 partial clear", cause, 6'h20);
    clr_mask = 6'h20; @(negedge clk); clr_mask = '0;
    chk(cause == 6'h20, "R12 mask without strobe", cause, 6'h20);
    clear_all();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule